// File: doc/BRIEF.md
# Linked-Descriptor Word DMA Engine

This engine serves a single storage peripheral. It moves 32-bit words between system memory and one data-port address on the peripheral side. Software builds a chain of descriptors in memory. Each descriptor is twelve words long. The engine is started by writing a 64-bit list pointer to one of two register pairs: one pair for the channel that moves data from memory to the device, and one for the channel that moves data from the device to memory. Control flags sit in the low five bits of that pointer, because the list itself must be aligned to 32 bytes.

Once started, the engine reads the descriptor through its memory master port. It then performs the word beats between the memory port and the peripheral port. When all beats are done it writes a completion mark into the descriptor's status word. It then follows the next-pointer if that pointer is flagged valid. When the last descriptor finishes, and that descriptor asks for it, a sticky done interrupt is raised. A stop flag written while the engine is running aborts the chain.

Top module: `linked_word_dma`

## Requirements
- R1: After reset the engine is idle. `busy`, `done_irq`, `mem_req` and `io_req` are all low, and no request is issued while `busy` is low.
- R2: The engine starts only when a low-half register write (`cfg_hi`=0) arrives while the engine is idle and has bit 3 set and bit 4 clear. The list base is the selected channel's stored high word joined to the written low word with bits 4:0 cleared. A write to the high half alone, a low-half write without bit 3, and any start while busy are all ignored.
- R3: The channel selected by `cfg_chan` (0 = memory-to-device pair, 1 = device-to-memory pair) keeps its own high word. A high-half write to one pair does not alter the other.
- R4: Bit 0 of the starting low word enables 64-bit addressing. When that bit is clear, the upper 32 bits of the list base, of every memory address and of every next pointer are zero, whatever the high words hold.
- R5: A descriptor at base B is read as words B+4*i. Word 0 is the next-pointer low, 1 the memory address low, 2 the peripheral address, 3 the length in words, 4 the step length in words, 5 the step count, 6 the command, 7 the status, 8 the next-pointer high and 9 the memory address high.
- R6: Command bit 12 set means each beat reads memory and then writes the peripheral. Command bit 12 clear means each beat reads the peripheral and then writes memory.
- R7: The peripheral address stays fixed across a descriptor's beats. The memory address starts at the descriptor's memory address and rises by 4 per word. A length of 0 performs no beats.
- R8: A descriptor performs max(step count, 1) runs of `length` words. Between runs the memory address skips an extra step-length words, so a step count of 0 or 1 gives one contiguous run.
- R9: After a descriptor completes, the next descriptor is fetched from {next high, next low with bit 0 cleared} when bit 0 of the next-pointer low word is 1. When that bit is 0 the chain ends.
- R10: When a descriptor's beats are done, the engine writes the value 1 to that descriptor's status word (B+28).
- R11: `done_irq` is set when the final descriptor of a chain finishes with command bit 1 set. It stays high until `irq_clear` is pulsed. Bit 1 of any other descriptor, or a final descriptor without bit 1, leaves it low.
- R12: A low-half write with bit 4 set while busy aborts the chain. The engine goes idle at the next completed transfer, and a beat whose read has completed still performs its write. No further status write and no interrupt follow. A stop while idle does nothing.
- R13: The engine holds a request, and its address, direction and write data, stable until the matching ready is seen. It never requests on the memory and peripheral ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_chan | input | 1 | Register pair select: 0 memory-to-device, 1 device-to-memory |
| cfg_hi | input | 1 | 1 selects the high half, 0 the low half (start/stop) |
| cfg_data | input | 32 | Register write data |
| irq_clear | input | 1 | Write-one-to-clear pulse for `done_irq` |
| done_irq | output | 1 | Sticky chain-complete interrupt |
| busy | output | 1 | Engine is walking a chain |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | Memory port write (1) or read (0) |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory transfer completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| io_req | output | 1 | Peripheral port request |
| io_we | output | 1 | Peripheral port write (1) or read (0) |
| io_addr | output | 32 | Peripheral data-port address |
| io_wdata | output | 32 | Peripheral write data |
| io_ready | input | 1 | Peripheral transfer completes this cycle |
| io_rdata | input | 32 | Peripheral read data, valid with `io_ready` |

## Verification
The assertions assume that both slave ports answer within a bounded time and that read data is valid in the same cycle as the ready signal. They also assume that `irq_clear` is a one-cycle pulse. The bench meets these with combinational memory and peripheral models whose ready lines are either held high or toggled on fixed cycle patterns, so requests stall without ever starving. Every descriptor the bench places sits at a 32-byte-aligned base inside the modelled memory, with non-overlapping data areas. Stop and start writes are only issued at points where the bench knows whether the engine is idle or busy.

// File: rtl/linked_word_dma.sv
module linked_word_dma #(
  parameter int DW = 32,
  parameter int IDXW = 4,
  parameter int LAST_FETCH = 9,
  parameter int STAT_WORD = 7,
  parameter logic [DW-1:0] DONE_MARK = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_chan,
  input  logic          cfg_hi,
  input  logic [DW-1:0] cfg_data,
  input  logic          irq_clear,
  output logic          done_irq,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          io_req,
  output logic          io_we,
  output logic [DW-1:0] io_addr,
  output logic [DW-1:0] io_wdata,
  input  logic          io_ready,
  input  logic [DW-1:0] io_rdata
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] STAT_OFS = AW'(STAT_WORD * 4);

  typedef enum logic [2:0] {IDLE, FETCH, RD, WR, STAT} st_t;
  st_t st;

  logic [DW-1:0] hi_q [2];
  logic          wide, stop_pend, to_io, want_irq;
  logic [AW-1:0] desc_base, cur_ma;
  logic [IDXW-1:0] idx;
  logic [DW-1:0] nxt_lo, nxt_hi, ma_lo, io_a, len_q, slen, scnt, left, runs, data_q;

  wire lo_wr    = cfg_wr & ~cfg_hi;
  wire start    = lo_wr & cfg_data[3] & ~cfg_data[4] & (st == IDLE);
  wire stop_req = stop_pend | (lo_wr & cfg_data[4]);
  wire fire     = (mem_req & mem_ready) | (io_req & io_ready);
  wire [DW-1:0] rdata = to_io ? mem_rdata : io_rdata;
  wire [AW-1:0] gap = {{(AW-DW-2){1'b0}}, slen, 2'b00};

  assign busy = (st != IDLE);

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = cur_ma; mem_wdata = data_q;
    io_req = 1'b0; io_we = 1'b0; io_addr = io_a; io_wdata = data_q;
    case (st)
      FETCH: begin
        mem_req = 1'b1;
        mem_addr = desc_base + {{(AW-IDXW-2){1'b0}}, idx, 2'b00};
      end
      RD: if (to_io) mem_req = 1'b1; else io_req = 1'b1;
      WR: if (to_io) begin io_req = 1'b1; io_we = 1'b1; end
          else begin mem_req = 1'b1; mem_we = 1'b1; end
      STAT: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc_base + STAT_OFS; mem_wdata = DONE_MARK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; hi_q[0] <= '0; hi_q[1] <= '0; wide <= 1'b0; stop_pend <= 1'b0;
      desc_base <= '0; cur_ma <= '0; idx <= '0; nxt_lo <= '0; nxt_hi <= '0;
      ma_lo <= '0; io_a <= '0; len_q <= '0; slen <= '0; scnt <= '0; left <= '0;
      runs <= '0; data_q <= '0; to_io <= 1'b0; want_irq <= 1'b0; done_irq <= 1'b0;
    end else begin
      if (cfg_wr && cfg_hi) hi_q[cfg_chan] <= cfg_data;
      if (irq_clear) done_irq <= 1'b0;
      if (busy && lo_wr && cfg_data[4]) stop_pend <= 1'b1;
      case (st)
        IDLE: begin
          stop_pend <= 1'b0;
          if (start) begin
            wide <= cfg_data[0];
            desc_base <= {cfg_data[0] ? hi_q[cfg_chan] : '0, cfg_data[DW-1:5], 5'b0};
            idx <= '0;
            st <= FETCH;
          end
        end
        FETCH: if (fire) begin
          if (stop_req) st <= IDLE;
          else begin
            idx <= idx + 1'b1;
            case (idx)
              0: nxt_lo <= mem_rdata;
              1: ma_lo  <= mem_rdata;
              2: io_a   <= mem_rdata;
              3: len_q  <= mem_rdata;
              4: slen   <= mem_rdata;
              5: scnt   <= mem_rdata;
              6: begin want_irq <= mem_rdata[1]; to_io <= mem_rdata[12]; end
              8: nxt_hi <= mem_rdata;
              default: ;
            endcase
            if (idx == IDXW'(LAST_FETCH)) begin
              cur_ma <= {wide ? mem_rdata : '0, ma_lo};
              left   <= len_q;
              runs   <= (scnt > 1) ? scnt - 1 : '0;
              st     <= (len_q == 0) ? STAT : RD;
            end
          end
        end
        RD: if (fire) begin
          data_q <= rdata;
          st <= stop_req ? IDLE : WR;
        end
        WR: if (fire) begin
          cur_ma <= cur_ma + AW'(4);
          if (stop_req) st <= IDLE;
          else if (left == 1) begin
            if (runs == 0) st <= STAT;
            else begin
              runs <= runs - 1; left <= len_q;
              cur_ma <= cur_ma + AW'(4) + gap; st <= RD;
            end
          end else begin
            left <= left - 1; st <= RD;
          end
        end
        STAT: if (fire) begin
          if (stop_req) st <= IDLE;
          else if (nxt_lo[0]) begin
            desc_base <= {wide ? nxt_hi : '0, nxt_lo[DW-1:1], 1'b0};
            idx <= '0;
            st <= FETCH;
          end else begin
            if (want_irq) done_irq <= 1'b1;
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module linked_word_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done_irq,
  input logic        irq_clear,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        io_req,
  input logic        io_we,
  input logic [31:0] io_addr,
  input logic [31:0] io_wdata,
  input logic        io_ready
);
  // R13
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && io_req));
  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R13
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ready |=> io_req && $stable(io_addr) && $stable(io_we) && $stable(io_wdata));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !io_req);
  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq && !irq_clear |=> done_irq);
  // R11
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $fell(busy));
endmodule

bind linked_word_dma linked_word_dma_chk u_chk (.*);

// File: tb/linked_word_dma_bench.sv
module linked_word_dma_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_wr, cfg_chan, cfg_hi, irq_clear, done_irq, busy;
  logic [31:0] cfg_data;
  logic mem_req, mem_we, mem_ready, io_req, io_we, io_ready;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, io_addr, io_wdata, io_rdata;

  linked_word_dma u_linked_word_dma (.*);

  logic [31:0] ram [0:255];
  logic [3:0] cyc = '0;
  logic stall = 1'b0;
  int io_reads = 0;
  assign mem_rdata = ram[mem_addr[9:2]];
  assign io_rdata  = 32'hC0DE_0000 | 32'(io_reads);
  assign mem_ready = !stall || cyc[0];
  assign io_ready  = !stall || cyc[1];

  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (mem_req && mem_we && mem_ready) ram[mem_addr[9:2]] <= mem_wdata;
    if (io_req && !io_we && io_ready) io_reads <= io_reads + 1;
  end

  logic [96:0] exp_q[$];
  string tag_q[$];
  logic [96:0] got_w, exp_w;
  string tag_w;
  int n_chk = 0, n_bad = 0, raw_io = 0, raw_mem = 0;
  bit sb_on = 1'b1;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if ((mem_req && mem_we && mem_ready) || (io_req && io_we && io_ready)) begin
      got_w = {io_req, io_req ? {32'h0, io_addr} : mem_addr, io_req ? io_wdata : mem_wdata};
      if (!sb_on) begin
        if (io_req) raw_io++; else raw_mem++;
      end else if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected write actual=%h expected=none", got_w);
      end else begin
        exp_w = exp_q.pop_front();
        tag_w = tag_q.pop_front();
        n_chk++;
        if (got_w !== exp_w) begin
          n_bad++;
          $display("FAIL %s write actual=%h expected=%h", tag_w, got_w, exp_w);
        end
      end
    end
  end

  task automatic push(bit io, logic [63:0] a, logic [31:0] d, string t);
    exp_q.push_back({io, a, d});
    tag_q.push_back(t);
  endtask

  task automatic cfg(bit ch, bit hi, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_chan = ch; cfg_hi = hi; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic put_desc(int w, logic [31:0] nlo, logic [31:0] malo, logic [31:0] ioa,
                          logic [31:0] len, logic [31:0] sl, logic [31:0] sc,
                          logic [31:0] cmd, logic [31:0] nhi, logic [31:0] mahi);
    ram[w] = nlo; ram[w+1] = malo; ram[w+2] = ioa; ram[w+3] = len;
    ram[w+4] = sl; ram[w+5] = sc; ram[w+6] = cmd; ram[w+7] = '0;
    ram[w+8] = nhi; ram[w+9] = mahi; ram[w+10] = '0; ram[w+11] = '0;
  endtask

  task automatic wait_idle(string r);
    int k = 0;
    @(negedge clk);
    while ((busy || exp_q.size() != 0) && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk({r, " chain drained"}, 64'(exp_q.size()), 64'd0);
    chk({r, " back to idle"}, {63'd0, busy}, 64'd0);
  endtask

  task automatic pulse_clear();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_chan = 1'b0; cfg_hi = 1'b0; cfg_data = '0; irq_clear = 1'b0;
    for (int i = 0; i < 256; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {60'd0, busy, done_irq, mem_req, io_req}, 64'd0);

    // R2 no start without bit 3, nor from a high write; R12 stop while idle
    cfg(0, 0, 32'h0000_0040);
    chk("R2 low write without start bit", {63'd0, busy}, 64'd0);
    cfg(0, 1, 32'h0000_0040);
    chk("R2 high write alone", {63'd0, busy}, 64'd0);
    cfg(0, 0, 32'h0000_0058);
    chk("R12 stop while idle", {63'd0, busy}, 64'd0);
    cfg(0, 1, 32'h0);

    // two-descriptor memory-to-device chain, stalled ports (R5 R6 R7 R9 R10 R13)
    put_desc(16, 32'h0000_0081, 32'h100, 32'h5000_0040, 3, 0, 1, 32'h1000, 0, 0);
    put_desc(32, 32'h0, 32'h180, 32'h5000_0040, 2, 0, 0, 32'h1002, 0, 0);
    for (int i = 0; i < 3; i++) ram[64+i] = 32'h1111_0000 + 32'(i);
    for (int i = 0; i < 2; i++) ram[96+i] = 32'h2222_0000 + 32'(i);
    for (int i = 0; i < 3; i++) push(1, 64'h5000_0040, 32'h1111_0000 + 32'(i), "R5 R6 R7 R13 beat A");
    push(0, 64'h5C, 32'h1, "R10 status A");
    for (int i = 0; i < 2; i++) push(1, 64'h5000_0040, 32'h2222_0000 + 32'(i), "R9 R8 beat B");
    push(0, 64'h9C, 32'h1, "R10 status B");
    stall = 1'b1;
    cfg(0, 0, 32'h0000_0048);
    chk("R2 start raises busy", {63'd0, busy}, 64'd1);
    cfg(1, 0, 32'h0000_0808);
    wait_idle("R2 start while busy ignored");
    chk("R11 done after final descriptor", {63'd0, done_irq}, 64'd1);
    repeat (3) @(negedge clk);
    chk("R11 sticky", {63'd0, done_irq}, 64'd1);
    pulse_clear();
    chk("R11 cleared", {63'd0, done_irq}, 64'd0);

    // device-to-memory with two runs and a gap (R8 R6 R3)
    put_desc(48, 32'h0, 32'h200, 32'h6000_0000, 2, 1, 2, 32'h0, 0, 0);
    base = io_reads;
    push(0, 64'h200, 32'hC0DE_0000 | 32'(base),     "R8 run0 word0");
    push(0, 64'h204, 32'hC0DE_0000 | 32'(base + 1), "R8 run0 word1");
    push(0, 64'h20C, 32'hC0DE_0000 | 32'(base + 2), "R8 run1 word0");
    push(0, 64'h210, 32'hC0DE_0000 | 32'(base + 3), "R8 run1 word1");
    push(0, 64'hDC, 32'h1, "R10 status C");
    cfg(1, 0, 32'h0000_00C8);
    wait_idle("R6 device to memory");
    chk("R11 no irq without bit 1", {63'd0, done_irq}, 64'd0);

    // 64-bit addressing with separate high words (R3 R4 R9)
    stall = 1'b0;
    cfg(0, 1, 32'h1);
    cfg(1, 1, 32'h7);
    put_desc(80, 32'h0000_01C1, 32'h300, 32'h7000_0000, 1, 0, 1, 32'h0, 1, 2);
    put_desc(112, 32'h0, 32'h340, 32'h7000_0000, 1, 0, 1, 32'h0, 0, 3);
    base = io_reads;
    push(0, {32'h2, 32'h300}, 32'hC0DE_0000 | 32'(base), "R4 wide mem address");
    push(0, {32'h1, 32'h15C}, 32'h1, "R3 own high word list base");
    push(0, {32'h3, 32'h340}, 32'hC0DE_0000 | 32'(base + 1), "R9 wide next pointer");
    push(0, {32'h1, 32'h1DC}, 32'h1, "R9 R10 status E");
    cfg(0, 0, 32'h0000_0149);
    wait_idle("R4 wide run");

    put_desc(80, 32'h0000_01C1, 32'h300, 32'h7000_0000, 1, 0, 1, 32'h0, 1, 2);
    put_desc(112, 32'h0, 32'h340, 32'h7000_0000, 1, 0, 1, 32'h0, 0, 3);
    base = io_reads;
    push(0, 64'h300, 32'hC0DE_0000 | 32'(base), "R4 narrow mem address");
    push(0, 64'h15C, 32'h1, "R4 narrow list base");
    push(0, 64'h340, 32'hC0DE_0000 | 32'(base + 1), "R4 narrow next pointer");
    push(0, 64'h1DC, 32'h1, "R4 narrow status E");
    cfg(0, 0, 32'h0000_0148);
    wait_idle("R4 narrow run");

    // zero length (R7)
    put_desc(16, 32'h0, 32'h100, 32'h5000_0040, 0, 0, 1, 32'h1002, 0, 0);
    push(0, 64'h5C, 32'h1, "R7 zero length status only");
    cfg(0, 0, 32'h0000_0048);
    wait_idle("R7 zero length");
    chk("R11 irq on zero-length final", {63'd0, done_irq}, 64'd1);
    pulse_clear();

    // abort (R12)
    sb_on = 1'b0; raw_io = 0; raw_mem = 0;
    put_desc(144, 32'h0, 32'h280, 32'h5000_0040, 20, 0, 1, 32'h1002, 0, 0);
    cfg(0, 0, 32'h0000_0248);
    for (int k = 0; k < 500 && raw_io < 3; k++) @(negedge clk);
    cfg(0, 0, 32'h0000_0010);
    repeat (6) @(negedge clk);
    chk("R12 idle after stop", {63'd0, busy}, 64'd0);
    chk("R12 beats cut short", {63'd0, (raw_io >= 3 && raw_io <= 5)}, 64'd1);
    chk("R12 no memory writes", 64'(raw_mem), 64'd0);
    chk("R12 status untouched", {32'd0, ram[151]}, 64'd0);
    chk("R12 no irq after stop", {63'd0, done_irq}, 64'd0);

    summary();
    $finish;
  end
endmodule